// File: doc/BRIEF.md
# Programmable Chip-Select and Wait-State Generator

This block decodes every bus cycle against four programmable address regions and drives one active-low select line per region. Each region has a start address, a power-of-two size from 8 KiB upward, a direction qualifier (read, write, both or neither), and an optional function-code qualifier. The start address is meant to sit on a multiple of the region size, and any start-address bits below the region size are ignored. Any bus master can run the cycle, because the block looks only at the strobe, address, direction and function code.

The block samples the address strobe on the rising clock edge. When the strobe is seen low while the block is idle, the address, direction and function code are captured. The matching select is then driven low and held for the whole cycle. If the winning region has automatic acknowledge enabled, an active-low data acknowledge is driven after the region's programmed number of wait states. When the strobe is seen high, every output is released. If more than one region matches, the lowest-numbered region wins.

The configuration arrives on static input vectors, one field per region packed side by side. Region i occupies slice i of each vector.

Top module: `csel_top`

## Requirements
- R1: While reset is low, all selects and the acknowledge are high.
- R2: A region with length code L (0..7) covers 8 KiB << L bytes. The base field holds address bits [23:13]. An address matches when its bits [23:13+L] equal the same bits of the base field, and base bits below the region size are ignored.
- R3: A region whose enable bit is 0 never drives its select.
- R4: The 2-bit access field allows a cycle by direction (rdWrN=1 is a read): 01 allows reads only, 10 allows writes only, 11 allows both, and 00 allows none.
- R5: When the any-code bit is 1, every function code matches. When it is 0, the 3-bit function code must equal the region's code.
- R6: When several regions match, only the lowest-numbered one drives its select, so at most one select is low at any time.
- R7: The select goes low after the first rising edge that samples the strobe low while idle. It then stays unchanged while the strobe stays low, even if the address, direction or function code change.
- R8: With acknowledge enabled, the acknowledge goes low N rising edges after the select goes low, where N is the wait field (0..6, and 7 acts as 6). With acknowledge disabled, it never goes low. It is never low without a select.
- R9: The first rising edge that samples the strobe high drives all selects and the acknowledge high, including the case where the wait count has not yet finished.
- R10: A cycle that matches no region drives no select and no acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| addrStrobeN | input | 1 | Address strobe, active low |
| addr | input | 24 | Byte address of the cycle |
| rdWrN | input | 1 | 1 = read, 0 = write |
| fc | input | 3 | Function code of the cycle |
| cfgEnable | input | 4 | Per-region enable |
| cfgBase | input | 44 | Per-region base bits [23:13], 11 bits each |
| cfgLength | input | 12 | Per-region length code, 3 bits each |
| cfgAccess | input | 8 | Per-region access field, 2 bits each |
| cfgFcAny | input | 4 | Per-region any-function-code bit |
| cfgFcCode | input | 12 | Per-region function code, 3 bits each |
| cfgAckEnable | input | 4 | Per-region automatic acknowledge enable |
| cfgWaits | input | 12 | Per-region wait count, 3 bits each |
| csN | output | 4 | Region selects, active low |
| dtackN | output | 1 | Data acknowledge, active low |

## Verification
Faults inside the block show up at the ports in a set number of edges. A wrong captured winner or a broken mask shows as a wrong select level one edge after the strobe is sampled low. A wrong wait counter moves the acknowledge edge away from the expected count, or lets it stay low into the next cycle. A stale busy state shows as a select that fails to rise one edge after the strobe returns high, or that fails to fall in the next cycle. The reference model compares both outputs on every clock, so each such fault is reported in the first cycle it affects.

// File: rtl/csel_pkg.sv
package csel_pkg;
  // Control-to-datapath strobes
  typedef struct packed {
    logic capture;   // latch winner and wait count
    logic tick;      // one wait state elapsed
    logic clear;     // strobe released, drop all outputs
  } csStrobe_t;

  typedef enum logic {ST_IDLE, ST_BUSY} csState_t;
endpackage

// File: rtl/csel_datapath.sv
module csel_datapath
  import csel_pkg::*;
#(
  parameter int NCH       = 4,
  parameter int ADDR_W    = 24,
  parameter int MIN_SHIFT = 13,
  parameter int LEN_W     = 3,
  parameter int FC_W      = 3,
  parameter int WAIT_W    = 3,
  parameter int MAX_WAIT  = 6
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  csStrobe_t                    strobe,
  input  logic [ADDR_W-1:0]            addr,
  input  logic                         rdWrN,
  input  logic [FC_W-1:0]              fc,
  input  logic [NCH-1:0]               cfgEnable,
  input  logic [NCH*(ADDR_W-MIN_SHIFT)-1:0] cfgBase,
  input  logic [NCH*LEN_W-1:0]         cfgLength,
  input  logic [NCH*2-1:0]             cfgAccess,
  input  logic [NCH-1:0]               cfgFcAny,
  input  logic [NCH*FC_W-1:0]          cfgFcCode,
  input  logic [NCH-1:0]               cfgAckEnable,
  input  logic [NCH*WAIT_W-1:0]        cfgWaits,
  output logic [NCH-1:0]               csN,
  output logic                         dtackN
);
  localparam int BASE_W = ADDR_W - MIN_SHIFT;
  localparam logic [WAIT_W-1:0] WAIT_CAP = WAIT_W'(MAX_WAIT);
  localparam logic [WAIT_W-1:0] WAIT_ONE = WAIT_W'(1);

  logic [BASE_W-1:0] addrUpper;
  logic [NCH-1:0]    hit;
  logic [NCH-1:0]    grant;
  logic [NCH:0]      claimedBelow;

  assign addrUpper       = addr[ADDR_W-1:MIN_SHIFT];
  assign claimedBelow[0] = 1'b0;

  for (genvar i = 0; i < NCH; i++) begin : g_region
    logic [BASE_W-1:0] baseField;
    logic [LEN_W-1:0]  lenField;
    logic [1:0]        accField;
    logic [BASE_W-1:0] sizeMask;
    logic              addrMatch;
    logic              dirOk;
    logic              fcOk;

    assign baseField = cfgBase[i*BASE_W +: BASE_W];
    assign lenField  = cfgLength[i*LEN_W +: LEN_W];
    assign accField  = cfgAccess[i*2 +: 2];
    // Keep only the address bits that lie above the region size
    assign sizeMask  = {BASE_W{1'b1}} << lenField;
    assign addrMatch = ((addrUpper ^ baseField) & sizeMask) == '0;
    assign dirOk     = rdWrN ? accField[0] : accField[1];
    assign fcOk      = cfgFcAny[i] | (fc == cfgFcCode[i*FC_W +: FC_W]);
    assign hit[i]    = cfgEnable[i] & addrMatch & dirOk & fcOk;

    // Fixed priority: lower index wins
    assign grant[i]          = hit[i] & ~claimedBelow[i];
    assign claimedBelow[i+1] = claimedBelow[i] | hit[i];
  end

  logic              winAck;
  logic [WAIT_W-1:0] winWait;
  logic [WAIT_W-1:0] winWaitCapped;

  always_comb begin
    winAck  = 1'b0;
    winWait = '0;
    for (int i = 0; i < NCH; i++) begin
      if (grant[i]) begin
        winAck  = winAck | cfgAckEnable[i];
        winWait = winWait | cfgWaits[i*WAIT_W +: WAIT_W];
      end
    end
    winWaitCapped = (winWait > WAIT_CAP) ? WAIT_CAP : winWait;
  end

  logic [NCH-1:0]    selQ;
  logic              ackArmQ;
  logic [WAIT_W-1:0] waitLeftQ;
  logic              ackQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selQ      <= '0;
      ackArmQ   <= 1'b0;
      waitLeftQ <= '0;
      ackQ      <= 1'b0;
    end else if (strobe.clear) begin
      selQ      <= '0;
      ackArmQ   <= 1'b0;
      waitLeftQ <= '0;
      ackQ      <= 1'b0;
    end else if (strobe.capture) begin
      selQ      <= grant;
      ackArmQ   <= winAck;
      waitLeftQ <= winWaitCapped;
      ackQ      <= winAck && (winWaitCapped == '0);
    end else if (strobe.tick) begin
      if (waitLeftQ != '0) begin
        waitLeftQ <= waitLeftQ - WAIT_ONE;
        if (waitLeftQ == WAIT_ONE && ackArmQ) ackQ <= 1'b1;
      end
    end
  end

  assign csN    = ~selQ;
  assign dtackN = ~ackQ;
endmodule

// File: rtl/csel_control.sv
module csel_control
  import csel_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      addrStrobeN,
  output csStrobe_t strobe
);
  csState_t state, stateNext;

  always_comb begin
    strobe    = '0;
    stateNext = state;
    case (state)
      ST_IDLE: begin
        if (!addrStrobeN) begin
          strobe.capture = 1'b1;
          stateNext      = ST_BUSY;
        end
      end
      ST_BUSY: begin
        if (addrStrobeN) begin
          strobe.clear = 1'b1;
          stateNext    = ST_IDLE;
        end else begin
          strobe.tick = 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end
endmodule

// File: rtl/csel_top.sv
module csel_top
  import csel_pkg::*;
#(
  parameter int NCH       = 4,
  parameter int ADDR_W    = 24,
  parameter int MIN_SHIFT = 13,
  parameter int LEN_W     = 3,
  parameter int FC_W      = 3,
  parameter int WAIT_W    = 3,
  parameter int MAX_WAIT  = 6
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              addrStrobeN,
  input  logic [ADDR_W-1:0]                 addr,
  input  logic                              rdWrN,
  input  logic [FC_W-1:0]                   fc,
  input  logic [NCH-1:0]                    cfgEnable,
  input  logic [NCH*(ADDR_W-MIN_SHIFT)-1:0] cfgBase,
  input  logic [NCH*LEN_W-1:0]              cfgLength,
  input  logic [NCH*2-1:0]                  cfgAccess,
  input  logic [NCH-1:0]                    cfgFcAny,
  input  logic [NCH*FC_W-1:0]               cfgFcCode,
  input  logic [NCH-1:0]                    cfgAckEnable,
  input  logic [NCH*WAIT_W-1:0]             cfgWaits,
  output logic [NCH-1:0]                    csN,
  output logic                              dtackN
);
  csStrobe_t strobe;

  csel_control u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .addrStrobeN(addrStrobeN),
    .strobe     (strobe)
  );

  csel_datapath #(
    .NCH(NCH), .ADDR_W(ADDR_W), .MIN_SHIFT(MIN_SHIFT), .LEN_W(LEN_W),
    .FC_W(FC_W), .WAIT_W(WAIT_W), .MAX_WAIT(MAX_WAIT)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .addr        (addr),
    .rdWrN       (rdWrN),
    .fc          (fc),
    .cfgEnable   (cfgEnable),
    .cfgBase     (cfgBase),
    .cfgLength   (cfgLength),
    .cfgAccess   (cfgAccess),
    .cfgFcAny    (cfgFcAny),
    .cfgFcCode   (cfgFcCode),
    .cfgAckEnable(cfgAckEnable),
    .cfgWaits    (cfgWaits),
    .csN         (csN),
    .dtackN      (dtackN)
  );
endmodule

// File: rtl/csel_checker.sv
module csel_checker #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rstN,
  input logic           addrStrobeN,
  input logic [NCH-1:0] csN,
  input logic           dtackN
);
  p_single_select_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~csN));

  p_ack_needs_select_r8: assert property (@(posedge clk) disable iff (!rstN)
    !dtackN |-> (~csN != '0));

  p_ack_holds_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!dtackN && !addrStrobeN) |=> !dtackN);

  p_select_holds_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!addrStrobeN && (~csN != '0)) |=> $stable(csN));

  p_release_r9: assert property (@(posedge clk) disable iff (!rstN)
    addrStrobeN |=> ((~csN == '0) && dtackN));
endmodule

bind csel_top csel_checker #(.NCH(NCH)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .addrStrobeN(addrStrobeN),
  .csN        (csN),
  .dtackN     (dtackN)
);

// File: tb/sim_csel_top.sv
module sim_csel_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        addrStrobeN = 1'b1;
  logic [23:0] addr = '0;
  logic        rdWrN = 1'b1;
  logic [2:0]  fc = '0;
  logic [3:0]  cfgEnable;
  logic [43:0] cfgBase;
  logic [11:0] cfgLength;
  logic [7:0]  cfgAccess;
  logic [3:0]  cfgFcAny;
  logic [11:0] cfgFcCode;
  logic [3:0]  cfgAckEnable;
  logic [11:0] cfgWaits;
  logic [3:0]  csN;
  logic        dtackN;

  logic        cEn[NCH];
  logic [10:0] cBase[NCH];
  logic [2:0]  cLen[NCH];
  logic [1:0]  cAcc[NCH];
  logic        cAny[NCH];
  logic [2:0]  cFc[NCH];
  logic        cAck[NCH];
  logic [2:0]  cWait[NCH];

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      cfgEnable[i]           = cEn[i];
      cfgBase[i*11 +: 11]    = cBase[i];
      cfgLength[i*3 +: 3]    = cLen[i];
      cfgAccess[i*2 +: 2]    = cAcc[i];
      cfgFcAny[i]            = cAny[i];
      cfgFcCode[i*3 +: 3]    = cFc[i];
      cfgAckEnable[i]        = cAck[i];
      cfgWaits[i*3 +: 3]     = cWait[i];
    end
  end

  csel_top u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int    nChecks = 0;
  int    nFails  = 0;
  int    cycles  = 0;
  bit    done    = 0;
  string curReq  = "R1";

  // Behavioural reference
  bit busy = 0;
  int expWin = -1;
  int waitsLeft = 0;
  bit expAck = 0;

  function automatic int pickRegion(int a, bit rd, int f);
    for (int i = 0; i < NCH; i++) begin
      int size  = 8192 << cLen[i];
      int start = ((int'(cBase[i]) * 8192) / size) * size;
      bit dirOk = rd ? cAcc[i][0] : cAcc[i][1];
      if (cEn[i] && a >= start && a < start + size && dirOk &&
          (cAny[i] || f == int'(cFc[i])))
        return i;
    end
    return -1;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!rstN) begin
      busy = 0; expWin = -1; expAck = 0; waitsLeft = 0;
    end else if (!busy) begin
      if (!addrStrobeN) begin
        busy   = 1;
        expWin = pickRegion(int'(addr), rdWrN, int'(fc));
        if (expWin >= 0 && cAck[expWin]) begin
          waitsLeft = (cWait[expWin] > 6) ? 6 : int'(cWait[expWin]);
          expAck    = (waitsLeft == 0);
        end else begin
          waitsLeft = -1;
          expAck    = 0;
        end
      end
    end else if (addrStrobeN) begin
      busy = 0; expWin = -1; expAck = 0;
    end else if (waitsLeft > 0) begin
      waitsLeft--;
      if (waitsLeft == 0) expAck = 1;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      logic [3:0] wantCs;
      wantCs = 4'hF;
      if (expWin >= 0) wantCs[expWin] = 1'b0;
      nChecks++;
      if (csN !== wantCs) begin
        nFails++;
        $display("FAIL %s csN actual=%b expected=%b t=%0t", curReq, csN, wantCs, $time);
      end
      nChecks++;
      if (dtackN !== !expAck) begin
        nFails++;
        $display("FAIL %s dtackN actual=%b expected=%b t=%0t", curReq, dtackN, !expAck, $time);
      end
    end
  end

  always @(posedge clk) begin
    if (cycles > 20000 && !done) begin
      done = 1;
      nFails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  task automatic setRegion(int i, bit en, int base, int len, int acc, bit any,
                           int code, bit ack, int w);
    cEn[i] = en; cBase[i] = 11'(base); cLen[i] = 3'(len); cAcc[i] = 2'(acc);
    cAny[i] = any; cFc[i] = 3'(code); cAck[i] = ack; cWait[i] = 3'(w);
  endtask

  // One bus cycle; optional address change while the strobe is low
  task automatic busCycle(string req, int a, bit rd, int f, int hold,
                          int altAddr = -1);
    @(negedge clk);
    curReq = req;
    addr = 24'(a); rdWrN = rd; fc = 3'(f); addrStrobeN = 1'b0;
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      if (k == 1 && altAddr >= 0) begin
        addr = 24'(altAddr); rdWrN = !rd; fc = 3'(f + 1);
      end
    end
    addrStrobeN = 1'b1;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < NCH; i++) setRegion(i, 0, 0, 0, 0, 1, 0, 0, 0);
    curReq = "R1";
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R2: 8K region at zero, read/write, ack with no wait
    setRegion(0, 1, 'h000, 0, 3, 1, 0, 1, 0);
    busCycle("R2", 'h001FFF, 1, 2, 3);
    busCycle("R10", 'h002000, 1, 2, 3);
    // R2: misaligned base bits ignored, 64K region, read-only, 3 waits
    setRegion(1, 1, 'h083, 3, 1, 1, 0, 1, 3);
    busCycle("R2", 'h10ABCD, 1, 0, 6);
    busCycle("R2", 'h10FFFF, 1, 0, 6);
    busCycle("R4", 'h10ABCD, 0, 0, 4);
    // R5/R8: write-only, code 5, wait 7 acts as 6
    setRegion(2, 1, 'h100, 1, 2, 0, 5, 1, 7);
    busCycle("R8", 'h202000, 0, 5, 9);
    busCycle("R5", 'h202000, 0, 6, 4);
    busCycle("R4", 'h202000, 1, 5, 4);
    busCycle("R10", 'h204000, 0, 5, 4);
    // R3: disabled, then enabled without ack
    setRegion(3, 0, 'h180, 0, 3, 1, 0, 0, 0);
    busCycle("R3", 'h301000, 1, 1, 4);
    cEn[3] = 1;
    busCycle("R8", 'h301000, 1, 1, 5);
    // R9: release before wait count ends
    busCycle("R9", 'h202000, 0, 5, 3);
    // R7: inputs change mid-cycle
    busCycle("R7", 'h10ABCD, 1, 0, 6, 'h204000);
    // R6: overlapping 1M regions
    setRegion(0, 1, 'h000, 7, 3, 1, 0, 1, 2);
    setRegion(3, 1, 'h000, 7, 3, 1, 0, 1, 1);
    busCycle("R6", 'h000100, 1, 3, 5);
    cAcc[0] = 2'b00;
    busCycle("R4", 'h000100, 1, 3, 5);
    // back-to-back cycles
    busCycle("R9", 'h10ABCD, 1, 0, 5);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule